// File: doc/BRIEF.md
# Gated Zero-Cross Trigger Pulse Generator

This block produces a fixed-width firing pulse for a triac driver each time an AC reference passes through zero. The reference is seen only as three digital flags from external comparators: one set while the input is above a positive hysteresis threshold, one set while it is below the matching negative threshold, and one giving the sign of the differential input. A crossing is recognised when the sign flips after the input has first gone beyond the threshold on the side it is leaving.

A gate input, normally a latched comparison result from elsewhere, qualifies the trigger. A crossing that happens while the gate is low makes no pulse but is still used up. After any crossing the block stays disarmed until it sees the threshold flag on the opposite side. This stops chatter around zero from firing the triac again. Once a pulse starts it always runs to full width.

Top module: `zc_trigger_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after its synchronised release, `trig_pulse` and `armed` are 0.
- R2: From reset, either hysteresis flag (`zc_above` or `zc_below`) arms the block, and `armed` reads 1 after the clock edge that samples the flag.
- R3: When armed from the positive side (`zc_above` was seen), a sampled `zc_sign` of 0 counts as a crossing. With `gate_en` = 1 on that edge, `trig_pulse` rises after the edge and stays high for exactly PULSE_CYCLES cycles.
- R4: When armed from the negative side, a sampled `zc_sign` of 1 counts as a crossing and fires the same pulse. A full sine cycle therefore gives two pulses.
- R5: A crossing sampled while `gate_en` = 0 produces no pulse, and `armed` reads 0 after it.
- R6: If `gate_en` drops while a pulse is running, the pulse still lasts the full PULSE_CYCLES cycles.
- R7: After a crossing, sign changes and the same-side flag do not re-arm the block or produce a pulse. Only the flag on the opposite side re-arms it.
- R8: A crossing sampled together with the opposite-side flag fires the pulse and leaves `armed` at 1, armed from the new side.
- R9: A second crossing sampled while a pulse is running neither restarts nor lengthens the pulse, but it is still consumed and `armed` reads 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| zc_above | input | 1 | Reference is above the positive hysteresis threshold |
| zc_below | input | 1 | Reference is below the negative hysteresis threshold |
| zc_sign | input | 1 | Sign of the reference: 1 = positive, 0 = negative |
| gate_en | input | 1 | Firing enable (latched comparison result) |
| trig_pulse | output | 1 | Triac firing pulse, PULSE_CYCLES cycles wide |
| armed | output | 1 | A crossing would currently be recognised |

## Verification
`armed` follows one clock edge after the flag or sign that changes it. `trig_pulse` goes high in the cycle after the edge that samples a qualifying crossing, so the bench drives each input shortly after a rising edge and reads the outputs 2 ns after the next one. Pulse width is measured by counting high cycles over a window that ends well after PULSE_CYCLES. This means a pulse that starts late or runs long is still counted, and the total is compared with PULSE_CYCLES or with zero. A sweep runs every combination of crossing direction and gate level from a fresh reset, and directed sequences cover chatter, the case where a crossing lands on the same edge as the opposite flag, and a crossing that arrives while a pulse is running.

// File: rtl/zc_trigger_pkg.sv
package zc_trigger_pkg;
  typedef enum logic [2:0] {
    ZS_IDLE     = 3'd0,
    ZS_ARM_POS  = 3'd1,
    ZS_ARM_NEG  = 3'd2,
    ZS_WAIT_NEG = 3'd3,
    ZS_WAIT_POS = 3'd4
  } zc_state_e;
endpackage

// File: rtl/zc_rst_sync.sv
module zc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/zc_arm_fsm.sv
module zc_arm_fsm
  import zc_trigger_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  input  logic sign_pos,
  output logic armed,
  output logic crossing
);
  zc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    crossing = 1'b0;
    case (state_q)
      ZS_IDLE: begin
        if (above_hi)      state_d = ZS_ARM_POS;
        else if (below_lo) state_d = ZS_ARM_NEG;
      end
      ZS_ARM_POS: begin
        if (!sign_pos) begin
          crossing = 1'b1;
          state_d  = below_lo ? ZS_ARM_NEG : ZS_WAIT_NEG;
        end
      end
      ZS_ARM_NEG: begin
        if (sign_pos) begin
          crossing = 1'b1;
          state_d  = above_hi ? ZS_ARM_POS : ZS_WAIT_POS;
        end
      end
      ZS_WAIT_NEG: if (below_lo) state_d = ZS_ARM_NEG;
      ZS_WAIT_POS: if (above_hi) state_d = ZS_ARM_POS;
      default:     state_d = ZS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ZS_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == ZS_ARM_POS) || (state_q == ZS_ARM_NEG);
endmodule

// File: rtl/zc_pulse_timer.sv
module zc_pulse_timer #(
  parameter int PULSE_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      cnt_en = 1'b1;
      busy_d = 1'b1;
      cnt_d  = LOAD_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/zc_trigger_gen.sv
module zc_trigger_gen #(
  parameter int PULSE_CYCLES = 2500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_above,
  input  logic zc_below,
  input  logic zc_sign,
  input  logic gate_en,
  output logic trig_pulse,
  output logic armed
);
  logic rst_sync_n;
  logic crossing;
  logic fire_start;

  zc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  zc_arm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .above_hi (zc_above),
    .below_lo (zc_below),
    .sign_pos (zc_sign),
    .armed    (armed),
    .crossing (crossing)
  );

  assign fire_start = crossing & gate_en;

  zc_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (fire_start),
    .busy  (trig_pulse)
  );
endmodule

// File: rtl/zc_trigger_chk.sv
module zc_trigger_chk #(
  parameter int PULSE_CYCLES = 2500
) (
  input logic clk,
  input logic rst_n,
  input logic zc_above,
  input logic zc_below,
  input logic gate_en,
  input logic trig_pulse,
  input logic armed
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (trig_pulse) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R5: a pulse only starts after an edge that saw the gate high
  p_gate_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_pulse) |-> $past(gate_en));

  // R3: a pulse only starts from the armed state
  p_fire_from_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_pulse) |-> $past(armed));

  // R2: arming always follows a sampled hysteresis flag
  p_arm_by_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(zc_above || zc_below));

  // R6: a pulse never runs past its length
  p_width_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (run_len < RUN_W'(PULSE_CYCLES)));

  // R6: a pulse that ends has run exactly its length
  p_width_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_pulse && run_len != '0) |-> (run_len == RUN_W'(PULSE_CYCLES)));
endmodule

bind zc_trigger_gen zc_trigger_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .zc_above   (zc_above),
  .zc_below   (zc_below),
  .gate_en    (gate_en),
  .trig_pulse (trig_pulse),
  .armed      (armed)
);

// File: tb/zc_trigger_gen_tb.sv
module zc_trigger_gen_tb;
  localparam int P = 5;

  logic clk, rst_n, zc_above, zc_below, zc_sign, gate_en;
  logic trig_pulse, armed;
  int checks, errors;

  zc_trigger_gen #(.PULSE_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .zc_above(zc_above), .zc_below(zc_below),
    .zc_sign(zc_sign), .gate_en(gate_en), .trig_pulse(trig_pulse), .armed(armed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive inputs, take one edge, outputs are then settled
  task automatic cyc(input logic ah, input logic bl, input logic sg, input logic en);
    zc_above = ah; zc_below = bl; zc_sign = sg; gate_en = en;
    @(posedge clk); #2;
  endtask

  // count pulse-high cycles over n edges with neutral flags
  task automatic count_fire(input int n, input logic sg, input logic en, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, sg, en);
      hi += int'(trig_pulse);
    end
  endtask

  task automatic do_reset();
    zc_above = 0; zc_below = 0; zc_sign = 1; gate_en = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset fire", int'(trig_pulse), 0);
    check("R1 reset armed", int'(armed), 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 post-release fire", int'(trig_pulse), 0);
    check("R1 post-release armed", int'(armed), 0);
  endtask

  initial begin
    checks = 0; errors = 0;
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    // Sweep direction x gate
    for (int dir = 0; dir < 2; dir++) begin
      for (int en = 0; en < 2; en++) begin
        do_reset();
        if (dir == 0) cyc(1, 0, 1, en[0]); else cyc(0, 1, 0, en[0]);
        check("R2 arm", int'(armed), 1);
        if (dir == 0) cyc(0, 0, 1, en[0]); else cyc(0, 0, 0, en[0]);
        check("R2 still armed", int'(armed), 1);
        if (dir == 0) cyc(0, 0, 0, en[0]); else cyc(0, 0, 1, en[0]);
        check(dir == 0 ? "R3 first cycle" : "R4 first cycle", int'(trig_pulse), en);
        check(en ? "R3/R4 disarm" : "R5 disarm", int'(armed), 0);
        count_fire(P + 4, dir == 0 ? 1'b0 : 1'b1, en[0], hi);
        hi += en;
        check(en ? (dir == 0 ? "R3 width" : "R4 width") : "R5 no pulse", hi, en ? P : 0);
      end
    end

    // R6: gate falls during pulse
    do_reset();
    cyc(1, 0, 1, 1);
    cyc(0, 0, 0, 1);
    count_fire(P + 4, 1'b0, 1'b0, hi);
    check("R6 width after gate drop", hi + 1, P);

    // R7: chatter and same-side flag after a falling crossing
    cyc(0, 0, 1, 1); cyc(0, 0, 0, 1); cyc(0, 0, 1, 1);
    cyc(1, 0, 1, 1);
    check("R7 same-side no re-arm", int'(armed), 0);
    count_fire(4, 1'b0, 1'b1, hi);
    check("R7 no chatter pulse", hi, 0);
    cyc(0, 1, 0, 1);
    check("R7 opposite re-arms", int'(armed), 1);
    cyc(0, 0, 1, 1);
    count_fire(P + 3, 1'b1, 1'b1, hi);
    check("R7 pulse after re-arm", hi + 1, P);

    // R8 and R9: crossing with opposite flag, then a crossing during the pulse
    do_reset();
    cyc(1, 0, 1, 1);
    cyc(0, 1, 0, 1);
    check("R8 fire", int'(trig_pulse), 1);
    check("R8 armed from new side", int'(armed), 1);
    cyc(0, 0, 1, 1);
    check("R9 consumed", int'(armed), 0);
    count_fire(P + 4, 1'b1, 1'b1, hi);
    check("R9 width unchanged", hi + 2, P);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule